// File: doc/BRIEF.md
# Halfword Instruction Fetch Aligner

This block sits between a source that delivers aligned 32-bit instruction words and the fetch port of a processor. Instructions there are either 16 or 32 bits long and may start on any halfword. The aligner slices each word into instructions and tells the two lengths apart from the two low bits of the first halfword. When a 32-bit instruction runs across two words, the aligner joins the halves with a one-halfword skid register. It also reports which of the two words holds a faulting half.

The core starts every fetch run with a one-cycle `branch` pulse that carries a halfword address. The aligner passes the word part of that address upstream as a redirect. It drops anything it is offering or holding, and it starts decoding in the halfword that the address selects. Each instruction is offered with valid/ready. A branch may withdraw an offer that has not been taken. Once an error has been taken, the aligner stops until the next branch.

Control is a four-state machine:
- NOADDR: no known fetch address.
- LOW: the lower halfword of the upstream word is next.
- HIGH: the upper halfword is next.
- JOIN: the skid register holds the first half of a 32-bit instruction, and the lower half of the next word completes it.

Transitions:
- Any state goes to LOW on a branch to a word address, and to HIGH on a branch to an upper halfword.
- LOW stays in LOW after a 32-bit instruction is taken, and goes to HIGH after a 16-bit one.
- HIGH goes to LOW after a 16-bit instruction is taken. It goes to JOIN when the upper halfword starts a 32-bit instruction, and that word is captured at the same time.
- JOIN goes to HIGH once the joined instruction is taken.
- LOW, HIGH and JOIN go to NOADDR once an errored instruction is taken.

Top module: `fetch_aligner`

## Requirements
- R1: From reset, and until the first branch, `valid` and `up_ready` stay low, even while `up_valid` is high.
- R2: In a branch cycle, `up_branch` is high and `up_fetch_waddr` equals `branch_addr` bits [AW-1:2]. No upstream word is taken in that cycle. The first instruction delivered after the branch has `addr` equal to the branch address, including a start in an upper halfword (address bit 1 set).
- R3: An instruction is 16 bits when bits [1:0] of its first halfword differ from 2'b11, and 32 bits otherwise. `rdata[15:0]` carries the first halfword, and for a 32-bit instruction `rdata[31:16]` carries the second. The next instruction's `addr` is the current one plus 2 or plus 4 accordingly.
- R4: Once `valid` is high with `req` high, it stays high until `ready` or `branch` is seen. While it is held, `addr`, `err` and `err_plus2` do not change.
- R5: While an offer is held, `rdata[15:0]` does not change. For a 32-bit instruction, all 32 bits of `rdata` stay unchanged.
- R6: A 32-bit instruction that starts in the upper halfword of a word takes its low 16 bits from that word and its high 16 bits from the lower half of the next word. Its `addr` is the upper halfword's address.
- R7: If the word holding an instruction's first halfword is errored, `err` is 1 and `err_plus2` is 0. If only the word holding the second halfword of a 32-bit instruction is errored, both are 1. `err_plus2` is never 1 together with `valid` and `err` when `rdata[1:0]` differs from 2'b11.
- R8: After an instruction with `err` is taken, `valid` and `up_ready` stay low until the next branch.
- R9: `valid` is low whenever `req` is low. A held offer reappears unchanged when `req` rises again.
- R10: A branch withdraws every instruction not yet taken. Only instructions from the new address follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Core is awake and may fetch |
| branch | input | 1 | One-cycle redirect strobe |
| branch_addr | input | AW-1 | Redirect target, address bits [AW-1:1] (bit 0 is zero) |
| ready | input | 1 | Core takes the offered instruction |
| valid | output | 1 | An instruction is offered |
| rdata | output | 32 | Instruction bits |
| addr | output | AW | Byte address of the offered instruction |
| err | output | 1 | Offered instruction has a fetch fault |
| err_plus2 | output | 1 | Fault lies in the second halfword's word |
| up_valid | input | 1 | Upstream word is present |
| up_ready | output | 1 | Upstream word is consumed this cycle |
| up_waddr | input | AW-2 | Word address of the upstream word |
| up_data | input | 32 | Upstream word data |
| up_err | input | 1 | Upstream word is faulty |
| up_branch | output | 1 | Redirect to upstream |
| up_fetch_waddr | output | AW-2 | Word address for the upstream redirect |

## Verification
The main function is tried with four input patterns, and each separates different faults:
- Runs starting on a word boundary and runs starting on an upper halfword tell a wrong start-halfword choice apart from wrong length decoding.
- Full-rate streams compared against streams with upstream gaps and core stalls show whether offers are held and stay stable, or are lost or duplicated when a word is only half used.
- Deliberate layouts place an errored word as the first word or as the second word of a 32-bit instruction that crosses a word boundary, which separates the two fault attributions.
- A branch issued while an offer is pending, and a `req` drop during a hold, show that a withdrawn instruction is never delivered and that a held one comes back.

// File: rtl/fa_pkg.sv
package fa_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [1:0] {
        ST_NOADDR,
        ST_LOW,
        ST_HIGH,
        ST_JOIN
    } fa_state_e;

    typedef enum logic [1:0] {
        SEL_LOW,
        SEL_HIGH,
        SEL_JOIN
    } fa_sel_e;
endpackage

// File: rtl/fa_len_detect.sv
module fa_len_detect
    import fa_pkg::*;
(
    input  logic [HALF_W-1:0] half,
    output logic              full
);
    // Only the two low bits of the first halfword decide the length.
    logic [HALF_W-3:0] unused_upper;
    assign unused_upper = half[HALF_W-1:2];
    assign full = (half[1:0] == 2'b11);
endmodule

// File: rtl/fa_skid.sv
module fa_skid
    import fa_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HALF_W-1:0] in_half,
    input  logic [AW-1:0]     in_addr,
    output logic [HALF_W-1:0] out_half,
    output logic [AW-1:0]     out_addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_half <= '0;
            out_addr <= '0;
        end else if (load) begin
            out_half <= in_half;
            out_addr <= in_addr;
        end
    end
endmodule

// File: rtl/fa_ctrl.sv
module fa_ctrl
    import fa_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    branch,
    input  logic    branch_hi,
    input  logic    ready,
    input  logic    up_valid,
    input  logic    up_err,
    input  logic    lo_full,
    input  logic    hi_full,
    output logic    offer,
    output fa_sel_e sel,
    output logic    o_err,
    output logic    o_ep2,
    output logic    take_word,
    output logic    skid_load
);
    fa_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NOADDR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        offer     = 1'b0;
        sel       = SEL_LOW;
        o_err     = 1'b0;
        o_ep2     = 1'b0;
        take_word = 1'b0;
        skid_load = 1'b0;
        unique case (state_q)
            ST_NOADDR: begin
            end
            ST_LOW: begin
                if (up_valid) begin
                    offer = 1'b1;
                    sel   = SEL_LOW;
                    o_err = up_err;
                    if (ready) begin
                        if (up_err) begin
                            take_word = 1'b1;
                            state_d   = ST_NOADDR;
                        end else if (lo_full) begin
                            take_word = 1'b1;
                        end else begin
                            state_d = ST_HIGH;
                        end
                    end
                end
            end
            ST_HIGH: begin
                if (up_valid) begin
                    if (up_err || !hi_full) begin
                        offer = 1'b1;
                        sel   = SEL_HIGH;
                        o_err = up_err;
                        if (ready) begin
                            take_word = 1'b1;
                            state_d   = up_err ? ST_NOADDR : ST_LOW;
                        end
                    end else begin
                        skid_load = 1'b1;
                        take_word = 1'b1;
                        state_d   = ST_JOIN;
                    end
                end
            end
            ST_JOIN: begin
                if (up_valid) begin
                    offer = 1'b1;
                    sel   = SEL_JOIN;
                    o_err = up_err;
                    o_ep2 = up_err;
                    if (ready) begin
                        if (up_err) begin
                            take_word = 1'b1;
                            state_d   = ST_NOADDR;
                        end else begin
                            state_d = ST_HIGH;
                        end
                    end
                end
            end
            default: state_d = ST_NOADDR;
        endcase
        if (branch) begin
            state_d   = branch_hi ? ST_HIGH : ST_LOW;
            take_word = 1'b0;
            skid_load = 1'b0;
        end
    end
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
    import fa_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              branch,
    input  logic [AW-1:1]     branch_addr,
    input  logic              ready,
    output logic              valid,
    output logic [WORD_W-1:0] rdata,
    output logic [AW-1:0]     addr,
    output logic              err,
    output logic              err_plus2,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [AW-3:0]     up_waddr,
    input  logic [WORD_W-1:0] up_data,
    input  logic              up_err,
    output logic              up_branch,
    output logic [AW-3:0]     up_fetch_waddr
);
    localparam int NHALF = WORD_W / HALF_W;

    logic [NHALF-1:0]  half_full;
    logic              offer;
    fa_sel_e           sel;
    logic              skid_load;
    logic [HALF_W-1:0] skid_half;
    logic [AW-1:0]     skid_addr;
    logic [AW-1:0]     word_addr;

    assign word_addr = {up_waddr, 2'b00};

    for (genvar g = 0; g < NHALF; g++) begin : g_len
        fa_len_detect u_len (
            .half (up_data[g*HALF_W +: HALF_W]),
            .full (half_full[g])
        );
    end

    fa_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .branch    (branch),
        .branch_hi (branch_addr[1]),
        .ready     (ready),
        .up_valid  (up_valid),
        .up_err    (up_err),
        .lo_full   (half_full[0]),
        .hi_full   (half_full[1]),
        .offer     (offer),
        .sel       (sel),
        .o_err     (err),
        .o_ep2     (err_plus2),
        .take_word (up_ready),
        .skid_load (skid_load)
    );

    fa_skid #(.AW(AW)) u_skid (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (skid_load),
        .in_half  (up_data[WORD_W-1:HALF_W]),
        .in_addr  (word_addr | AW'(2)),
        .out_half (skid_half),
        .out_addr (skid_addr)
    );

    assign valid          = offer & req;
    assign up_branch      = branch;
    assign up_fetch_waddr = branch_addr[AW-1:2];

    always_comb begin
        unique case (sel)
            SEL_HIGH: begin
                rdata = {{HALF_W{1'b0}}, up_data[WORD_W-1:HALF_W]};
                addr  = word_addr | AW'(2);
            end
            SEL_JOIN: begin
                rdata = {up_data[HALF_W-1:0], skid_half};
                addr  = skid_addr;
            end
            default: begin
                rdata = up_data;
                addr  = word_addr;
            end
        endcase
    end
endmodule

// File: rtl/fetch_aligner_chk.sv
module fetch_aligner_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          branch,
    input logic          ready,
    input logic          valid,
    input logic [31:0]   rdata,
    input logic [AW-1:0] addr,
    input logic          err,
    input logic          err_plus2,
    input logic          up_ready
);
    logic has_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            has_addr <= 1'b0;
        end else if (branch) begin
            has_addr <= 1'b1;
        end else if (valid && ready && err) begin
            has_addr <= 1'b0;
        end
    end

    a_r4_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready && !branch |=> valid || !req);
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready && !branch |=> $stable(addr));
    a_r4_err_stable: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready && !branch |=> $stable(err) && $stable(err_plus2));
    a_r5_low_half_stable: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready && !branch |=> $stable(rdata[15:0]));
    a_r5_full_stable: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready && !branch && !err && rdata[1:0] == 2'b11 |=> $stable(rdata));
    a_r7_ep2_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        valid && err && err_plus2 |-> rdata[1:0] == 2'b11);
    a_r8_quiet_without_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !has_addr |-> !valid && !up_ready);
    a_r2_no_take_on_branch: assert property (@(posedge clk) disable iff (!rst_n)
        branch |-> !up_ready);
endmodule

bind fetch_aligner fetch_aligner_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .branch    (branch),
    .ready     (ready),
    .valid     (valid),
    .rdata     (rdata),
    .addr      (addr),
    .err       (err),
    .err_plus2 (err_plus2),
    .up_ready  (up_ready)
);

// File: tb/fetch_aligner_test.sv
module fetch_aligner_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          branch = 1'b0;
    logic [AW-1:1] branch_addr = '0;
    logic          ready = 1'b0;
    logic          valid;
    logic [31:0]   rdata;
    logic [AW-1:0] addr;
    logic          err;
    logic          err_plus2;
    logic          up_valid = 1'b0;
    logic          up_ready;
    logic [AW-3:0] up_waddr = '0;
    logic [31:0]   up_data = '0;
    logic          up_err = 1'b0;
    logic          up_branch;
    logic [AW-3:0] up_fetch_waddr;

    fetch_aligner #(.AW(AW)) uut (.*);

    always #5 clk = ~clk;

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        logic        e;
        logic        e2;
        logic        full;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] mem [0:255];
    int          err_word = -1;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    bit          cmd_branch = 0;
    logic [31:0] cmd_addr = '0;
    int          cmd_n = 0;
    string       cmd_tag = "R2";
    bit          stall_mode = 0;
    bit          gap_mode = 0;
    bit          hold_ready = 0;

    function automatic logic [15:0] gen_half(int k);
        logic [15:0] h;
        h = 16'(k * 40503) ^ 16'(k << 5) ^ 16'h5a3c;
        if (h[6]) h[1:0] = 2'b11;
        else if (h[1:0] == 2'b11) h[1:0] = 2'b01;
        return h;
    endfunction

    function automatic bit word_bad(logic [31:0] wi);
        return int'(wi) == err_word;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver side of the scoreboard: walk the memory model from a start address.
    task automatic push_walk(logic [31:0] a0, int n, string tag0);
        logic [31:0] a;
        a = a0;
        for (int k = 0; k < n; k++) begin
            logic [31:0] wi;
            logic [15:0] lo16, hi16;
            bit          e1, e2;
            exp_t        it;
            wi   = {2'b00, a[31:2]};
            lo16 = a[1] ? mem[wi[7:0]][31:16] : mem[wi[7:0]][15:0];
            e1   = word_bad(wi);
            it.a = a;
            it.tag = (k == 0) ? tag0 : "R3";
            if (e1) begin
                it.d = '0; it.e = 1'b1; it.e2 = 1'b0; it.full = 1'b0;
                if (k != 0) it.tag = "R7";
                exp_q.push_back(it);
                break;
            end
            if (lo16[1:0] != 2'b11) begin
                it.d = {16'h0, lo16}; it.e = 1'b0; it.e2 = 1'b0; it.full = 1'b0;
                exp_q.push_back(it);
                a = a + 2;
            end else begin
                hi16 = a[1] ? mem[wi[7:0] + 8'd1][15:0] : mem[wi[7:0]][31:16];
                e2   = a[1] ? word_bad(wi + 1) : 1'b0;
                it.d = {hi16, lo16}; it.e = e2; it.e2 = e2; it.full = 1'b1;
                if (k != 0) it.tag = e2 ? "R7" : (a[1] ? "R6" : "R3");
                exp_q.push_back(it);
                if (e2) break;
                a = a + 4;
            end
        end
    endtask

    // Combined stimulus and monitor loop, one pass per clock, away from the edge.
    initial begin
        logic [31:0] ptr = '0;
        bit          src_hold = 0;
        bit          up_took = 0;
        bit          saw_branch = 0;
        logic [31:0] saw_addr = '0;
        bit          prev_stall = 0;
        logic [31:0] p_addr = '0, p_rdata = '0;
        logic        p_err = 1'b0, p_ep2 = 1'b0;
        int          cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (saw_branch) begin
                ptr = saw_addr; src_hold = 0;
            end else if (up_took) begin
                ptr = ptr + 1; src_hold = 0;
            end
            branch = 1'b0;
            if (cmd_branch) begin
                branch      = 1'b1;
                branch_addr = cmd_addr[AW-1:1];
                exp_q.delete();
                push_walk(cmd_addr, cmd_n, cmd_tag);
                cmd_branch  = 0;
            end
            ready = req && exp_q.size() > 0 && !hold_ready && !(stall_mode && (cyc % 3 == 1));
            if (!src_hold) up_valid = !(gap_mode && (cyc % 4 == 2));
            up_waddr = ptr[AW-3:0];
            up_data  = mem[ptr[7:0]];
            up_err   = word_bad(ptr);
            #1;
            saw_branch = up_branch;
            saw_addr   = {2'b00, up_fetch_waddr};
            up_took    = up_valid && up_ready;
            src_hold   = up_valid && !up_ready;
            if (branch) begin
                check(!up_ready, "R2", "up_ready in branch cycle", 64'(up_ready), 64'd0);
                check(up_branch && up_fetch_waddr == cmd_addr[AW-1:2], "R2", "redirect word",
                      64'(up_fetch_waddr), 64'(cmd_addr[AW-1:2]));
            end
            if (prev_stall && !branch) begin
                check(valid || !req, "R4", "valid dropped while held", 64'(valid), 64'd1);
                check(addr == p_addr && err == p_err && err_plus2 == p_ep2, "R4",
                      "addr/err changed while held", {addr, 30'd0, err, err_plus2},
                      {p_addr, 30'd0, p_err, p_ep2});
                check(rdata[15:0] == p_rdata[15:0], "R5", "rdata low changed while held",
                      64'(rdata[15:0]), 64'(p_rdata[15:0]));
            end
            prev_stall = valid && !ready && !branch;
            p_addr = addr; p_rdata = rdata; p_err = err; p_ep2 = err_plus2;
            if (valid && ready && !branch) begin
                if (exp_q.size() == 0) begin
                    check(0, "R10", "unexpected instruction", 64'(addr), 64'd0);
                end else begin
                    exp_t e;
                    bit   ok;
                    e  = exp_q.pop_front();
                    ok = (addr == e.a) && (err == e.e) && (err_plus2 == e.e2);
                    if (!e.e) begin
                        ok = ok && (rdata[15:0] == e.d[15:0]);
                        if (e.full) ok = ok && (rdata == e.d);
                    end
                    check(ok, e.tag, "delivered instruction",
                          {addr, e.e ? 16'h0 : rdata[15:0], 14'd0, err, err_plus2},
                          {e.a, e.e ? 16'h0 : e.d[15:0], 14'd0, e.e, e.e2});
                end
            end
        end
    end

    task automatic start_branch(logic [31:0] a, int n, string tag);
        @(posedge clk);
        cmd_addr = a; cmd_n = n; cmd_tag = tag; cmd_branch = 1;
    endtask

    task automatic drain();
        while (cmd_branch || exp_q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = {gen_half(2 * i + 1), gen_half(2 * i)};
        mem[40] = {16'h2c47, 16'h3a01};

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk); #3;
            check(!valid && !up_ready, "R1", "idle before first branch",
                  64'({valid, up_ready}), 64'd0);
        end
        @(posedge clk);
        req = 1'b1;
        repeat (2) begin
            @(negedge clk); #3;
            check(!valid && !up_ready, "R1", "idle with req, no branch",
                  64'({valid, up_ready}), 64'd0);
        end

        // Word-aligned start, full rate
        start_branch(32'h100, 24, "R2");
        drain();
        // Upper-halfword start with core stalls and upstream gaps
        stall_mode = 1; gap_mode = 1;
        start_branch(32'h182, 24, "R2");
        drain();
        // Branch while earlier instructions are still pending
        start_branch(32'h40, 12, "R2");
        repeat (3) @(posedge clk);
        start_branch(32'h202, 10, "R10");
        drain();
        stall_mode = 0; gap_mode = 0;

        // Fault in the word of the first halfword
        err_word = 50;
        start_branch(32'hCA, 4, "R7");
        drain();
        repeat (4) begin
            @(negedge clk); #3;
            check(!valid && !up_ready, "R8", "quiet after taken error",
                  64'({valid, up_ready}), 64'd0);
        end
        start_branch(32'hC4, 8, "R2");
        drain();
        // Fault only in the word of the second halfword
        err_word = 41;
        start_branch(32'hA0, 4, "R6");
        drain();
        repeat (3) begin
            @(negedge clk); #3;
            check(!valid && !up_ready, "R8", "quiet after joined error",
                  64'({valid, up_ready}), 64'd0);
        end
        err_word = -1;

        // req gating of a held offer
        hold_ready = 1;
        start_branch(32'h300, 3, "R9");
        repeat (4) @(posedge clk);
        @(negedge clk); #3;
        check(valid, "R9", "offer before req drop", 64'(valid), 64'd1);
        @(posedge clk); req = 1'b0;
        @(negedge clk); #3;
        check(!valid, "R9", "valid with req low", 64'(valid), 64'd0);
        @(posedge clk); req = 1'b1;
        @(negedge clk); #3;
        check(valid && addr == 32'h300, "R9", "offer after req rise", 64'(addr), 64'h300);
        @(posedge clk); hold_ready = 0;
        drain();

        done = 1;
        summary();
    end
endmodule